// File: doc/BRIEF.md
# Single-Core Interrupt Controller with Acknowledge and End-of-Interrupt

This block collects interrupt requests from software and from hardware lines, keeps a four-way lifecycle state for every interrupt ID, and presents a single request line to one processor. Each ID has its own enable, an 8-bit priority and, for hardware-driven IDs, a choice of edge or level sensitivity. The processor drives a valid-qualified command port to configure IDs and to raise software interrupts. An acknowledge command returns the ID of the most urgent enabled pending interrupt and marks it as in service. An end-of-interrupt command names an ID and retires its service.

There are 64 IDs. IDs 0 to 15 can only be raised by a command. IDs 16 to 31 are per-core peripheral lines, and IDs 32 to 63 are shared peripheral lines. Both of those ranges enter on one hardware vector. A lower priority value is more urgent. The request output is held back while the processor is already serving something at least as urgent.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every ID is inactive and disabled, with priority 0xFF and level mode. `irq` is low and `ack_valid` is low.
- R2: Opcode 3 raises ID `cmd_id` only when that ID is in 0..15 and enabled. A raise naming an ID of 16 or above, or a disabled ID, has no effect.
- R3: In edge mode, a rising edge on `hw_lines[k]` makes ID k+16 pending if the ID is enabled. A line held high does not raise the ID again.
- R4: In level mode, an enabled ID becomes pending while its line is high. If the line falls before the ID is acknowledged, the pending state is dropped.
- R5: Opcode 4 (acknowledge) returns the enabled pending ID with the lowest priority value, with ties going to the lowest ID. `ack_valid` is high for exactly the cycle after the command, and `ack_id` carries the result.
- R6: An acknowledge moves the chosen ID from pending to active, or from active-and-pending to active.
- R7: Triggering an active ID moves it to active-and-pending. An end-of-interrupt on that ID then leaves it pending.
- R8: Opcode 5 (end-of-interrupt) moves an active ID to inactive. An end-of-interrupt naming an ID that is not active is ignored.
- R9: An acknowledge with no enabled pending ID returns 1023 and changes no state.
- R10: `irq` is high exactly when some enabled ID is pending and its priority value is strictly below that of every active ID.
- R11: A level-mode ID whose line is still high at end-of-interrupt is pending again afterwards.
- R12: The configuration opcodes use `cmd_data`. Opcode 0 sets the enable from bit 0. Opcode 1 sets the priority from all 8 bits. Opcode 2 sets the mode from bit 0, where 1 is edge and 0 is level. A disabled pending ID is neither signalled nor acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_lines | input | 48 | Hardware request lines; bit k drives ID k+16 |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 0 enable, 1 priority, 2 mode, 3 raise, 4 acknowledge, 5 end-of-interrupt |
| cmd_id | input | 10 | Target interrupt ID |
| cmd_data | input | 8 | Configuration data |
| ack_valid | output | 1 | Acknowledge result strobe |
| ack_id | output | 10 | Acknowledged ID, or 1023 if none |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Software raises on IDs with equal priorities separate the lowest-ID tie-break from the plain priority order. A more urgent raise arriving during service checks preemption against the running priority. Hardware lines are tried in both modes. A line held high after service separates edge behaviour (no retrigger) from level behaviour (re-entry after end-of-interrupt). A line dropped before acknowledge exercises level withdrawal. Stray end-of-interrupt commands, raises on out-of-range IDs, disabled IDs and retriggers of active IDs each cover one of the four-state transitions, and every result is read back through the acknowledge port.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned ID_W        = 10;
  localparam int unsigned SPURIOUS_ID = 1023;

  typedef enum logic [2:0] {
    OP_ENABLE = 3'd0,
    OP_PRIO   = 3'd1,
    OP_MODE   = 3'd2,
    OP_RAISE  = 3'd3,
    OP_ACK    = 3'd4,
    OP_EOI    = 3'd5
  } irq_op_e;

  // bit 1: in service, bit 0: waiting
  typedef enum logic [1:0] {
    IS_IDLE = 2'b00,
    IS_PEND = 2'b01,
    IS_ACT  = 2'b10,
    IS_BOTH = 2'b11
  } irq_state_e;

endpackage

// File: rtl/irq_cell.sv
module irq_cell
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned PRIO_W   = 8,
  parameter bit          HAS_LINE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              prio_we,
  input  logic              mode_we,
  input  logic [PRIO_W-1:0] cfg_data,
  input  logic              sgi_set,
  input  logic              ack_hit,
  input  logic              eoi_hit,
  input  logic              line_in,
  output logic              cand,
  output logic              act,
  output logic [PRIO_W-1:0] prio
);

  irq_state_e        st_q, st_d;
  logic              en_q, en_d;
  logic              edge_q, edge_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              line_q;
  logic              set_evt, clr_evt;
  logic              nx_pend, nx_act;

  // trigger qualification
  always_comb begin
    set_evt = 1'b0;
    clr_evt = 1'b0;
    if (en_q && sgi_set) set_evt = 1'b1;
    if (HAS_LINE) begin
      if (edge_q) begin
        if (en_q && line_in && !line_q) set_evt = 1'b1;
      end else begin
        if (en_q && line_in) set_evt = 1'b1;
        if (!line_in)        clr_evt = 1'b1;
      end
    end
  end

  // next state: service transitions first, then trigger effects
  always_comb begin
    nx_pend = st_q[0];
    nx_act  = st_q[1];
    if (ack_hit && nx_pend) begin
      nx_pend = 1'b0;
      nx_act  = 1'b1;
    end
    if (eoi_hit && nx_act) nx_act = 1'b0;
    if (set_evt) nx_pend = 1'b1;
    if (clr_evt) nx_pend = 1'b0;
    st_d = irq_state_e'({nx_act, nx_pend});
  end

  always_comb begin
    en_d   = en_we   ? cfg_data[0] : en_q;
    edge_d = mode_we ? cfg_data[0] : edge_q;
    prio_d = prio_we ? cfg_data    : prio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IS_IDLE;
      en_q   <= 1'b0;
      edge_q <= 1'b0;
      prio_q <= '1;
      line_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      edge_q <= edge_d;
      prio_q <= prio_d;
      line_q <= line_in;
    end
  end

  assign cand = en_q && st_q[0];
  assign act  = st_q[1];
  assign prio = prio_q;

endmodule

// File: rtl/irq_min_pick.sv
module irq_min_pick #(
  parameter int unsigned N      = 64,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             sel,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     found,
  output logic [IDX_W-1:0]         idx,
  output logic [PRIO_W-1:0]        best
);

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < int'(N); i++) begin
      if (sel[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned NUM_PPI = 16,
  parameter int unsigned NUM_SPI = 32,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned NUM_ID  = NUM_SGI + NUM_PPI + NUM_SPI,
  localparam int unsigned NUM_HW  = NUM_PPI + NUM_SPI,
  localparam int unsigned IDX_W   = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_lines,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [PRIO_W-1:0] cmd_data,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_id,
  output logic              irq
);

  logic [NUM_ID-1:0]             cand_vec;
  logic [NUM_ID-1:0]             act_vec;
  logic [NUM_ID-1:0][PRIO_W-1:0] prio_vec;

  logic              id_ok;
  logic              do_en, do_prio, do_mode, do_raise, do_ack, do_eoi;
  logic              win_found, run_found;
  logic [IDX_W-1:0]  win_idx, run_idx;
  logic [PRIO_W-1:0] win_prio, run_prio;
  logic              ack_valid_q, ack_valid_d;
  logic [ID_W-1:0]   ack_id_q, ack_id_d;

  assign id_ok    = cmd_id < ID_W'(NUM_ID);
  assign do_en    = cmd_valid && id_ok && (cmd_op == OP_ENABLE);
  assign do_prio  = cmd_valid && id_ok && (cmd_op == OP_PRIO);
  assign do_mode  = cmd_valid && id_ok && (cmd_op == OP_MODE);
  assign do_raise = cmd_valid && (cmd_id < ID_W'(NUM_SGI)) && (cmd_op == OP_RAISE);
  assign do_ack   = cmd_valid && (cmd_op == OP_ACK);
  assign do_eoi   = cmd_valid && id_ok && (cmd_op == OP_EOI);

  for (genvar g = 0; g < int'(NUM_ID); g++) begin : g_cell
    logic sel_id;
    logic line_w;
    assign sel_id = (cmd_id == ID_W'(g));
    if (g < int'(NUM_SGI)) begin : g_sw
      assign line_w = 1'b0;
    end else begin : g_hw
      assign line_w = hw_lines[g - int'(NUM_SGI)];
    end
    irq_cell #(
      .PRIO_W   (PRIO_W),
      .HAS_LINE (g >= int'(NUM_SGI))
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we    (do_en   && sel_id),
      .prio_we  (do_prio && sel_id),
      .mode_we  (do_mode && sel_id),
      .cfg_data (cmd_data),
      .sgi_set  (do_raise && sel_id),
      .ack_hit  (do_ack && win_found && (win_idx == IDX_W'(g))),
      .eoi_hit  (do_eoi && sel_id),
      .line_in  (line_w),
      .cand     (cand_vec[g]),
      .act      (act_vec[g]),
      .prio     (prio_vec[g])
    );
  end

  irq_min_pick #(.N(NUM_ID), .PRIO_W(PRIO_W)) u_pick_pend (
    .sel   (cand_vec),
    .prio  (prio_vec),
    .found (win_found),
    .idx   (win_idx),
    .best  (win_prio)
  );

  irq_min_pick #(.N(NUM_ID), .PRIO_W(PRIO_W)) u_pick_run (
    .sel   (act_vec),
    .prio  (prio_vec),
    .found (run_found),
    .idx   (run_idx),
    .best  (run_prio)
  );

  always_comb begin
    ack_valid_d = do_ack;
    ack_id_d    = ack_id_q;
    if (do_ack) ack_id_d = win_found ? ID_W'(win_idx) : ID_W'(SPURIOUS_ID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_q <= 1'b0;
      ack_id_q    <= ID_W'(SPURIOUS_ID);
    end else begin
      ack_valid_q <= ack_valid_d;
      ack_id_q    <= ack_id_d;
    end
  end

  assign ack_valid = ack_valid_q;
  assign ack_id    = ack_id_q;
  assign irq       = win_found && (!run_found || (win_prio < run_prio));

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_ID = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ID)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              ack_valid,
  input logic [ID_W-1:0]   ack_id,
  input logic              irq,
  input logic [NUM_ID-1:0] cand_vec,
  input logic [NUM_ID-1:0] act_vec
);

  a_r5_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACK) |=> ack_valid);

  a_r5_ack_caused: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(cmd_valid && cmd_op == OP_ACK));

  a_r9_spurious_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id == ID_W'(SPURIOUS_ID)) |-> ($past(cand_vec) == '0));

  a_r5_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id != ID_W'(SPURIOUS_ID)) |-> (ack_id < ID_W'(NUM_ID)));

  a_r6_acked_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id < ID_W'(NUM_ID)) |-> act_vec[ack_id[IDX_W-1:0]]);

  a_r10_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cand_vec != '0));

endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_ID(NUM_ID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .ack_valid (ack_valid),
  .ack_id    (ack_id),
  .irq       (irq),
  .cand_vec  (cand_vec),
  .act_vec   (act_vec)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SPUR       = 1023;

  logic        clk;
  logic        rst_n;
  logic [47:0] hw_lines;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [9:0]  cmd_id;
  logic [7:0]  cmd_data;
  logic        ack_valid;
  logic [9:0]  ack_id;
  logic        irq;

  int checks;
  int errors;
  int exp_q[$];
  string tag_q[$];
  bit done;

  irq_ctrl u_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_lines  (hw_lines),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_id    (cmd_id),
    .cmd_data  (cmd_data),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmd(input logic [2:0] op, input int id, input int data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_id    = 10'(id);
    cmd_data  = 8'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic setup(input int id, input int prio, input int edge_m);
    cmd(3'd1, id, prio);
    cmd(3'd2, id, edge_m);
    cmd(3'd0, id, 1);
  endtask

  task automatic ack_expect(input int exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cmd(3'd4, 0, 0);
  endtask

  task automatic check_irq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic hw(input int id, input logic v);
    @(negedge clk);
    hw_lines[id-16] = v;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected ack actual %0d expected none", ack_id);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(ack_id) != e) begin
          errors++;
          $display("FAIL %s ack actual %0d expected %0d", t, ack_id, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; hw_lines = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_id = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    checks++;
    if (ack_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 ack_valid actual %0b expected 0", ack_valid);
    end
    check_irq(1'b0, "R1");
    ack_expect(SPUR, "R1/R9 empty");

    // R5 R10 R12 software priorities and tie-break
    setup(3, 8'h40, 0);
    setup(5, 8'h40, 0);
    setup(7, 8'h10, 0);
    cmd(3'd3, 5, 0);
    cmd(3'd3, 3, 0);
    check_irq(1'b1, "R10 pending");
    ack_expect(3, "R5 tie lowest id");
    check_irq(1'b0, "R10 equal running");
    cmd(3'd3, 7, 0);
    check_irq(1'b1, "R10 preempt");
    ack_expect(7, "R5 priority");
    cmd(3'd5, 7, 0);
    cmd(3'd5, 3, 0);
    check_irq(1'b1, "R8 retire");
    ack_expect(5, "R5 remaining");
    cmd(3'd5, 5, 0);
    check_irq(1'b0, "R8 all idle");
    ack_expect(SPUR, "R9 none");

    // R8 end-of-interrupt on a pending id ignored
    cmd(3'd3, 3, 0);
    cmd(3'd5, 3, 0);
    ack_expect(3, "R8 eoi on pending ignored");
    cmd(3'd5, 3, 0);
    ack_expect(SPUR, "R8 eoi retires active");

    // R6 R7 active-and-pending paths
    cmd(3'd3, 3, 0);
    ack_expect(3, "R6 first");
    cmd(3'd3, 3, 0);
    check_irq(1'b0, "R7 own active blocks");
    ack_expect(3, "R6 both to active");
    cmd(3'd5, 3, 0);
    ack_expect(SPUR, "R6 single service");
    cmd(3'd3, 3, 0);
    ack_expect(3, "R7 first");
    cmd(3'd3, 3, 0);
    cmd(3'd5, 3, 0);
    ack_expect(3, "R7 eoi leaves pending");
    cmd(3'd5, 3, 0);

    // R2 raise rules
    cmd(3'd3, 9, 0);
    cmd(3'd0, 9, 1);
    ack_expect(SPUR, "R2 disabled raise");
    setup(20, 8'h30, 1);
    cmd(3'd3, 20, 0);
    ack_expect(SPUR, "R2 raise above 15");
    cmd(3'd0, 20, 0);

    // R3 edge mode
    setup(40, 8'h20, 1);
    hw(40, 1'b1);
    check_irq(1'b1, "R3 edge");
    ack_expect(40, "R3 edge ack");
    cmd(3'd5, 40, 0);
    ack_expect(SPUR, "R3 held line no retrigger");
    hw(40, 1'b0);
    hw(40, 1'b1);
    ack_expect(40, "R3 second edge");
    cmd(3'd5, 40, 0);
    hw(40, 1'b0);

    // R4 R11 level mode
    setup(20, 8'h30, 0);
    hw(20, 1'b1);
    check_irq(1'b1, "R4 level high");
    hw(20, 1'b0);
    check_irq(1'b0, "R4 level withdrawn");
    ack_expect(SPUR, "R4 withdrawn not acked");
    hw(20, 1'b1);
    ack_expect(20, "R11 first");
    check_irq(1'b0, "R11 held in service");
    cmd(3'd5, 20, 0);
    ack_expect(20, "R11 re-enter after eoi");
    hw(20, 1'b0);
    cmd(3'd5, 20, 0);
    ack_expect(SPUR, "R11 line low retired");

    // R12 disabled hardware id
    cmd(3'd2, 50, 1);
    hw(50, 1'b1);
    check_irq(1'b0, "R12 disabled");
    ack_expect(SPUR, "R12 disabled not acked");
    hw(50, 1'b0);

    // R5 mixed sources
    setup(45, 8'h80, 1);
    setup(33, 8'h80, 1);
    setup(60, 8'h08, 1);
    cmd(3'd3, 3, 0);
    @(negedge clk);
    hw_lines[45-16] = 1'b1; hw_lines[33-16] = 1'b1; hw_lines[60-16] = 1'b1;
    ack_expect(60, "R5 hw most urgent");
    ack_expect(3, "R5 sw next");
    ack_expect(33, "R5 hw tie low id");
    ack_expect(45, "R5 last");
    ack_expect(SPUR, "R9 drained");
    cmd(3'd5, 45, 0);
    cmd(3'd5, 33, 0);
    cmd(3'd5, 3, 0);
    cmd(3'd5, 60, 0);
    check_irq(1'b0, "R10 idle end");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 missing acks actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule